// File: doc/BRIEF.md
# Banked Scratchpad with Bank-Conflict Replay

This block is a scratchpad memory that serves one warp-wide access at a time. The access has 32 lanes. Each lane carries a valid flag, a word address, a write flag and 32-bit write data. The words are spread over 32 single-ported banks, and each bank can perform one access per clock.

When several lanes address different words that live in the same bank, the block replays that bank over successive cycles. Lanes that land on the same word share one bank access, which acts as a broadcast. Within a bank, the pending word of the lowest-numbered lane is served first. The block reports when every lane has been served and presents the read data of all lanes at that point.

A caller raises `req_i` with the lane vectors while `busy_o` is low. It then waits for the one-cycle `done_o` pulse, which marks the cycle in which `lane_rdata_o` is valid. Requests are never merged, so conflicts are only ever counted among the lanes of one request.

Top module: `smem_banked`

## Requirements
- R1: A lane's bank is the low 5 bits of its word address (address mod 32) and its row is the remaining upper bits, so word 32 sits in bank 0 and shares that bank with word 0; with the default 32 rows the address space is 1024 words.
- R2: A request is taken on a rising edge where `req_i` is high and `busy_o` is low; `req_i` and the lane inputs have no effect while `busy_o` is high.
- R3: After acceptance `busy_o` is high for exactly N cycles, where N is the largest number of distinct words requested in any one bank (at least 1); `done_o` is a single-cycle pulse in the cycle after the last busy cycle, with `busy_o` low.
- R4: Any number of lanes reading the same word are served by one bank access in the same cycle, and all of them receive that word.
- R5: Lanes that address distinct words of one bank are served one word per cycle, so 32 lanes hitting 32 different rows of one bank take 32 cycles.
- R6: A request whose lanes touch each bank with at most one distinct word completes in one cycle.
- R7: A valid lane with its write flag set stores its data at its word, and later reads of that word return it.
- R8: When several lanes of one request write the same word, the data of the highest-numbered such lane is stored.
- R9: A lane whose valid flag is low makes no access. In the `done_o` cycle, its `lane_rdata_o` slot is zero, and so is the slot of every writing lane. A request with no valid lane takes one busy cycle.
- R10: A reading lane that shares its word with a writing lane of the same request returns the word's content from before that request.
- R11: In reset and before the first request, `busy_o`, `done_o` and every `lane_rdata_o` slot are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, taken when busy_o is low |
| lane_valid_i | input | LANES | Per-lane access enable |
| lane_addr_i | input | LANES x ADDR_W | Per-lane word address |
| lane_we_i | input | LANES | Per-lane write flag |
| lane_wdata_i | input | LANES x DATA_W | Per-lane write data |
| busy_o | output | 1 | High while a request is being served |
| done_o | output | 1 | One-cycle pulse when every lane has been served |
| lane_rdata_o | output | LANES x DATA_W | Per-lane read data, valid while done_o is high |

## Verification
The bench builds the block with its default parameters: 32 lanes, 32 banks and 32 rows per bank. This makes a full 32-way conflict on one bank reachable, as well as a broadcast to all 32 lanes and partial conflicts of 2 and 3 words. It also allows an address at the very top row and bank of the space. The bench checks each request's busy-cycle count against a conflict count it computes itself, and it checks every lane's data against a word-level model of the memory.

// File: rtl/smem_pkg.sv
package smem_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } smem_state_e;
endpackage

// File: rtl/smem_bank_store.sv
module smem_bank_store #(
  parameter int ROWS   = 32,
  parameter int DATA_W = 32,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [ROWS];

  // single port: read returns content before this cycle's write
  assign rd_data_o = mem_q[row_i];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[row_i] <= wr_data_i;
  end
endmodule

// File: rtl/smem_bank_arbiter.sv
module smem_bank_arbiter #(
  parameter int LANES   = 32,
  parameter int BANKS   = 32,
  parameter int ROWS    = 32,
  parameter int DATA_W  = 32,
  parameter int BANK_ID = 0,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int ADDR_W = BANK_W + ROW_W
) (
  input  logic [LANES-1:0]             pend_i,
  input  logic [LANES-1:0][ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]             we_i,
  input  logic [LANES-1:0][DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]             grant_o,
  output logic [ROW_W-1:0]             row_o,
  output logic                         wr_en_o,
  output logic [DATA_W-1:0]            wr_data_o
);
  logic [LANES-1:0] hit;
  logic             found;

  always_comb begin
    found = 1'b0;
    row_o = '0;
    for (int l = 0; l < LANES; l++) begin
      hit[l] = pend_i[l] && (addr_i[l][BANK_W-1:0] == BANK_W'(BANK_ID));
      // lowest pending lane picks the row served this cycle
      if (hit[l] && !found) begin
        found = 1'b1;
        row_o = addr_i[l][ADDR_W-1:BANK_W];
      end
    end
    wr_en_o   = 1'b0;
    wr_data_o = '0;
    for (int l = 0; l < LANES; l++) begin
      grant_o[l] = hit[l] && (addr_i[l][ADDR_W-1:BANK_W] == row_o);
      // ascending scan: highest writing lane wins
      if (grant_o[l] && we_i[l]) begin
        wr_en_o   = 1'b1;
        wr_data_o = wdata_i[l];
      end
    end
  end
endmodule

// File: rtl/smem_banked.sv
module smem_banked
  import smem_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ROWS   = 32,
  parameter int DATA_W = 32,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int ADDR_W = BANK_W + ROW_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic [LANES-1:0]             lane_valid_i,
  input  logic [LANES-1:0][ADDR_W-1:0] lane_addr_i,
  input  logic [LANES-1:0]             lane_we_i,
  input  logic [LANES-1:0][DATA_W-1:0] lane_wdata_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic [LANES-1:0][DATA_W-1:0] lane_rdata_o
);
  smem_state_e                  state_q;
  logic                         done_q;
  logic [LANES-1:0]             pend_q;
  logic [LANES-1:0][ADDR_W-1:0] addr_q;
  logic [LANES-1:0]             we_q;
  logic [LANES-1:0][DATA_W-1:0] wdata_q;
  logic [LANES-1:0][DATA_W-1:0] rdata_q;

  logic [BANKS-1:0][LANES-1:0]  bank_grant;
  logic [BANKS-1:0][DATA_W-1:0] bank_rdata;
  logic [LANES-1:0]             grant_all;
  logic [LANES-1:0]             pend_nxt;
  logic                         accept;

  assign busy_o       = (state_q == ST_RUN);
  assign done_o       = done_q;
  assign lane_rdata_o = rdata_q;
  assign accept       = req_i && !busy_o;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [ROW_W-1:0]  row;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;

    smem_bank_arbiter #(
      .LANES(LANES), .BANKS(BANKS), .ROWS(ROWS), .DATA_W(DATA_W), .BANK_ID(b)
    ) u_arb (
      .pend_i   (pend_q),
      .addr_i   (addr_q),
      .we_i     (we_q),
      .wdata_i  (wdata_q),
      .grant_o  (bank_grant[b]),
      .row_o    (row),
      .wr_en_o  (wr_en),
      .wr_data_o(wr_data)
    );

    smem_bank_store #(.ROWS(ROWS), .DATA_W(DATA_W)) u_store (
      .clk_i    (clk_i),
      .row_i    (row),
      .wr_en_i  (wr_en),
      .wr_data_i(wr_data),
      .rd_data_o(bank_rdata[b])
    );
  end

  always_comb begin
    grant_all = '0;
    for (int b = 0; b < BANKS; b++) grant_all |= bank_grant[b];
    pend_nxt = pend_q & ~grant_all;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      pend_q  <= '0;
      addr_q  <= '0;
      we_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (accept) begin
      state_q <= ST_RUN;
      done_q  <= 1'b0;
      pend_q  <= lane_valid_i;
      addr_q  <= lane_addr_i;
      we_q    <= lane_we_i;
      wdata_q <= lane_wdata_i;
      rdata_q <= '0;
    end else if (busy_o) begin
      pend_q <= pend_nxt;
      for (int l = 0; l < LANES; l++) begin
        if (grant_all[l] && !we_q[l]) rdata_q[l] <= bank_rdata[addr_q[l][BANK_W-1:0]];
      end
      if (pend_nxt == '0) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  a_r2_accept_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o);
  a_r3_done_follows_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));
  a_r3_busy_ends_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r3_done_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_pending_only_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ((pend_q & ~$past(pend_q)) == '0));
  a_r9_grant_only_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_all & ~pend_q) == '0);
endmodule

// File: tb/smem_banked_tb.sv
module smem_banked_tb_top;
  localparam int LANES = 32;
  localparam int AW    = 10;
  localparam int DW    = 32;
  localparam int WORDS = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [LANES-1:0]         valid = '0;
  logic [LANES-1:0][AW-1:0] addr = '0;
  logic [LANES-1:0]         we = '0;
  logic [LANES-1:0][DW-1:0] wdata = '0;
  logic busy, done;
  logic [LANES-1:0][DW-1:0] rdata;

  logic [DW-1:0] model [WORDS];
  logic [LANES-1:0][DW-1:0] exp_rd;
  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  smem_banked dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .lane_valid_i(valid), .lane_addr_i(addr), .lane_we_i(we), .lane_wdata_i(wdata),
    .busy_o(busy), .done_o(done), .lane_rdata_o(rdata)
  );

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] expv);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic int exp_cycles();
    int worst = 1;
    for (int b = 0; b < 32; b++) begin
      int cnt = 0;
      for (int l = 0; l < LANES; l++) begin
        if (valid[l] && addr[l][4:0] == 5'(b)) begin
          bit seen = 1'b0;
          for (int k = 0; k < l; k++) if (valid[k] && addr[k] == addr[l]) seen = 1'b1;
          if (!seen) cnt++;
        end
      end
      if (cnt > worst) worst = cnt;
    end
    return worst;
  endfunction

  // expected read data from pre-request model, then apply writes lane-ascending
  task automatic model_apply();
    for (int l = 0; l < LANES; l++)
      exp_rd[l] = (valid[l] && !we[l]) ? model[addr[l]] : '0;
    for (int l = 0; l < LANES; l++)
      if (valid[l] && we[l]) model[addr[l]] = wdata[l];
  endtask

  task automatic wait_done(inout int cyc);
    int guard = 0;
    while (!done && guard < 200) begin
      if (busy) cyc++;
      guard++;
      @(negedge clk);
    end
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL R3 done never seen actual=0 expected=1");
    end
  endtask

  task automatic check_lanes(string tag);
    for (int l = 0; l < LANES; l++) chk($sformatf("%s lane%0d", tag, l), rdata[l], exp_rd[l]);
  endtask

  task automatic run_req(string tag_cyc, string tag_dat);
    int cyc = 0;
    int ecyc;
    ecyc = exp_cycles();
    model_apply();
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_done(cyc);
    chk({tag_cyc, " busy cycles"}, DW'(cyc), DW'(ecyc));
    chk({tag_cyc, " busy low at done"}, DW'(busy), '0);
    check_lanes(tag_dat);
  endtask

  task automatic clear_stim();
    valid = '0; addr = '0; we = '0; wdata = '0;
  endtask

  task automatic t_reset();
    chk("R11 busy in reset", DW'(busy), '0);
    chk("R11 done in reset", DW'(done), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 busy after reset", DW'(busy), '0);
    chk("R11 done after reset", DW'(done), '0);
    chk("R11 rdata after reset", DW'(|rdata), '0);
  endtask

  task automatic t_fill();
    for (int r = 0; r < 32; r++) begin
      clear_stim();
      for (int l = 0; l < LANES; l++) begin
        valid[l] = 1'b1; we[l] = 1'b1;
        addr[l]  = AW'(r * 32 + l);
        wdata[l] = 32'hA500_0000 ^ ((r * 32 + l) * 32'h0001_9E37);
      end
      run_req("R6 fill", "R9 writer rdata");
    end
  endtask

  task automatic t_readback();
    for (int r = 0; r < 32; r += 5) begin
      clear_stim();
      for (int l = 0; l < LANES; l++) begin
        valid[l] = 1'b1;
        addr[l] = AW'(((r + l) % 32) * 32 + l);
      end
      run_req("R6 spread read", "R7 readback");
    end
  endtask

  task automatic t_mapping();
    clear_stim();
    valid[0] = 1'b1; addr[0] = 10'd5;
    valid[1] = 1'b1; addr[1] = 10'd37;
    run_req("R1 same bank 5/37", "R1 data 5/37");
    clear_stim();
    valid[0] = 1'b1; addr[0] = 10'd5;
    valid[1] = 1'b1; addr[1] = 10'd6;
    valid[2] = 1'b1; addr[2] = 10'd1023;
    run_req("R1 distinct banks", "R1 data top word");
  endtask

  task automatic t_serial();
    clear_stim();
    for (int l = 0; l < LANES; l++) begin
      valid[l] = 1'b1;
      addr[l] = AW'(l * 32 + 9);
    end
    run_req("R5 32-way conflict", "R5 serial data");
  endtask

  task automatic t_mixed();
    clear_stim();
    valid[3:0] = 4'hF;
    addr[0] = 10'd35; addr[1] = 10'd67; addr[2] = 10'd35; addr[3] = 10'd163;
    for (int l = 4; l < LANES; l++) begin
      valid[l] = 1'b1;
      addr[l] = AW'(l + ((l % 2) ? 64 : 0));
    end
    valid[12] = 1'b1; addr[12] = 10'd12;
    addr[13] = 10'd13 + 10'd96;
    run_req("R3 three-word bank", "R4 shared word in conflict");
  endtask

  task automatic t_same_writers();
    clear_stim();
    valid[4] = 1'b1;  we[4] = 1'b1;  addr[4] = 10'd100;  wdata[4] = 32'h1111_1111;
    valid[9] = 1'b1;  we[9] = 1'b1;  addr[9] = 10'd100;  wdata[9] = 32'h2222_2222;
    valid[20] = 1'b1; we[20] = 1'b1; addr[20] = 10'd100; wdata[20] = 32'h3333_3333;
    run_req("R8 multi writer", "R8 writer rdata");
    clear_stim();
    for (int l = 0; l < LANES; l++) begin
      valid[l] = 1'b1;
      addr[l] = 10'd100;
    end
    run_req("R4 broadcast", "R8 highest lane stored");
  endtask

  task automatic t_rw_share();
    clear_stim();
    valid[0] = 1'b1; addr[0] = 10'd200;
    valid[5] = 1'b1; addr[5] = 10'd200; we[5] = 1'b1; wdata[5] = 32'h0000_BEEF;
    valid[6] = 1'b1; addr[6] = 10'd200;
    run_req("R10 read with writer", "R10 old value");
    clear_stim();
    valid[1] = 1'b1; addr[1] = 10'd200;
    run_req("R7 single read", "R7 new value");
  endtask

  task automatic t_empty();
    clear_stim();
    we = '1;
    for (int l = 0; l < LANES; l++) begin
      addr[l] = AW'(l * 32);
      wdata[l] = 32'hFFFF_0000;
    end
    run_req("R9 empty request", "R9 invalid lanes zero");
    clear_stim();
    for (int l = 0; l < LANES; l++) begin
      valid[l] = 1'b1;
      addr[l] = AW'(l * 32);
    end
    run_req("R9 no write by invalid", "R9 memory untouched");
  endtask

  task automatic t_busy_ignore();
    int cyc = 0;
    int ecyc;
    clear_stim();
    for (int l = 0; l < 4; l++) begin
      valid[l] = 1'b1;
      addr[l] = AW'(l * 32 + 7);
    end
    ecyc = exp_cycles();
    model_apply();
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    cyc = busy ? 1 : 0;
    valid = '1; we = '1; wdata = '1;
    for (int l = 0; l < LANES; l++) addr[l] = 10'd7;
    @(negedge clk);
    req = 1'b0;
    wait_done(cyc);
    chk("R2 busy cycles with ignored req", DW'(cyc), DW'(ecyc));
    check_lanes("R2 data unaffected");
    clear_stim();
    valid[0] = 1'b1; addr[0] = 10'd7;
    run_req("R2 readback", "R2 word 7 not overwritten");
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_fill();
    t_readback();
    t_mapping();
    t_serial();
    t_mixed();
    t_same_writers();
    t_rw_share();
    t_empty();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(5 * 100000);
    vectors++;
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule